// File: doc/BRIEF.md
# Shift-Left-Arithmetic Decode and Execute Unit

This unit accepts the byte stream of a single shift-left-arithmetic instruction for an 8-bit accumulator CPU, one byte per handshake. It recognises an optional width-suffix byte, an optional index-register prefix, the shift prefix, a signed displacement and the closing opcode byte. From these it selects the operand: a general register, the byte addressed by HL, or the byte at IX or IY plus the displacement. It shifts the operand left by one place and builds the new flag byte. It then reports the result, the destination and the cycle count of the decoded form on a result channel.

Register contents come in on plain input ports from the surrounding register file. The unit writes nothing there itself. The consumer applies a reported register result. Memory operands go through a simple byte port with a one-cycle read latency. The unit reads the operand, then writes the shifted byte back to the same address.

Both stream directions use valid/ready. A byte moves when `in_valid` and `in_ready` are both high on a rising edge. `in_ready` stays low from the final byte of an instruction until its result has been taken. A result is held, stable, while `res_valid` is high and `res_ready` is low. It is consumed on the edge where both are high.

Top module: `sla_exec_unit`

## Requirements
- R1: The result byte is the operand shifted left by one bit, with bit 0 set to zero. Flag bit 0 (carry) receives the operand's old bit 7.
- R2: Flag bit 7 (sign) equals result bit 7. Flag bit 6 (zero) is 1 exactly when the result is 0x00.
- R3: Flag bit 4 (half-carry) and flag bit 1 (add/subtract) are always 0 on a legal result. Flag bits 5 and 3 are copied from `flags_in`.
- R4: Flag bit 2 (parity/overflow) is 1 when the result holds an even number of one bits, zero included.
- R5: The register form is 0xCB then 0b00100rrr, with rrr codes B=000, C=001, D=010, E=011, H=100, L=101, A=111. `regs_in` packs seven bytes, lowest first: B, C, D, E, H, L, A. `res_reg` reports rrr and `res_mem` is 0.
- R6: 0xCB then 0x26 operates on memory at {H,L}. The unit pulses `mem_rd_en` at that address. One cycle later it pulses `mem_wr_en` with the shifted byte at the same address. `res_mem` is 1 and `res_reg` is 110.
- R7: 0xDD (IX) or 0xFD (IY), then 0xCB, then a displacement byte, then 0x26 operates on memory at the index value plus the sign-extended displacement.
- R8: A leading 0x52 is a suffix that is legal only when `mode_wide` is 1. A leading 0x49 is a suffix that is legal only when `mode_wide` is 0. A suffix may precede only the (HL) or indexed forms.
- R9: `res_cycles` is 2 for a register operand, 5 for (HL) and 7 for an indexed operand, plus 1 when a suffix was present.
- R10: An unexpected byte at any step ends the instruction with `res_illegal` = 1. `res_flags` then equals `flags_in`, `res_cycles` is 0, and no memory write occurs. Decoding restarts at the next byte.
- R11: While a result is pending, `in_ready` is 0 and `res_valid`, `res_data` and `res_flags` stay stable until `res_ready` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wide | input | 1 | Address-mode flag that decides which suffix byte is legal |
| in_valid | input | 1 | Instruction byte valid |
| in_ready | output | 1 | Unit can accept an instruction byte |
| in_byte | input | 8 | Instruction byte |
| regs_in | input | 56 | Register bytes B, C, D, E, H, L, A, lowest first |
| flags_in | input | 8 | Current flag byte |
| ix_in | input | ADDR_W | IX index register |
| iy_in | input | ADDR_W | IY index register |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_rd_en | output | 1 | Read strobe; data is returned on the following cycle |
| mem_rdata | input | 8 | Read data |
| mem_wr_en | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_illegal | output | 1 | Instruction was rejected |
| res_mem | output | 1 | Result was written to memory |
| res_reg | output | 3 | Destination register code |
| res_data | output | 8 | Shifted byte |
| res_flags | output | 8 | New flag byte |
| res_cycles | output | 4 | Cycle count of the decoded form |

## Verification
A decoder that keeps a stale prefix or suffix marker corrupts the next instruction, not the current one. It shows up as a wrong cycle count or a false illegal report on the very next result. The bench therefore runs forms back to back, with and without prefixes. A wrong displacement or index selection appears as a wrong write address in the same instruction's write-back strobe, two cycles after its final byte. An execute sequencer stuck outside idle holds `in_ready` low, and the next byte push stalls until the watchdog fires.

// File: rtl/sla_pkg.sv
package sla_pkg;

  localparam logic [7:0] OP_SFX_SHORT = 8'h52;
  localparam logic [7:0] OP_SFX_LONG  = 8'h49;
  localparam logic [7:0] OP_PFX_IX    = 8'hDD;
  localparam logic [7:0] OP_PFX_IY    = 8'hFD;
  localparam logic [7:0] OP_PFX_SHIFT = 8'hCB;
  localparam logic [4:0] OP_SLA_HI    = 5'b00100;
  localparam logic [2:0] RRR_MEM      = 3'b110;

  localparam int FL_S  = 7;
  localparam int FL_Z  = 6;
  localparam int FL_H  = 4;
  localparam int FL_PV = 2;
  localparam int FL_N  = 1;
  localparam int FL_C  = 0;

  localparam int CYC_W = 4;

  typedef struct packed {
    logic       illegal;
    logic       is_mem;
    logic       use_idx;
    logic       sel_iy;
    logic       sfx;
    logic [2:0] rrr;
    logic [7:0] disp;
  } dec_t;

  function automatic logic [CYC_W-1:0] form_cycles(input logic is_mem,
                                                   input logic use_idx,
                                                   input logic sfx);
    logic [CYC_W-1:0] base;
    base = !is_mem ? CYC_W'(2) : (use_idx ? CYC_W'(7) : CYC_W'(5));
    return base + CYC_W'(sfx);
  endfunction

endpackage

// File: rtl/sla_shift_alu.sv
module sla_shift_alu
  import sla_pkg::*;
(
  input  logic [7:0] op_i,
  input  logic [7:0] flags_i,
  output logic [7:0] res_o,
  output logic [7:0] flags_o
);

  logic [7:0] shifted;

  always_comb begin
    shifted      = {op_i[6:0], 1'b0};
    res_o        = shifted;
    flags_o      = flags_i;
    flags_o[FL_S]  = shifted[7];
    flags_o[FL_Z]  = (shifted == 8'h00);
    flags_o[FL_H]  = 1'b0;
    flags_o[FL_PV] = ~^shifted;
    flags_o[FL_N]  = 1'b0;
    flags_o[FL_C]  = op_i[7];
  end

endmodule

// File: rtl/sla_prefix_decoder.sv
module sla_prefix_decoder
  import sla_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wide,
  input  logic       accept_en,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_byte,
  output logic       dec_valid,
  output dec_t       dec
);

  typedef enum logic [2:0] {
    D_FIRST, D_SFX, D_IDXCB, D_DISP, D_OP
  } dstate_t;

  dstate_t    st_q, st_d;
  logic       sfx_q, sfx_d;
  logic       idx_q, idx_d;
  logic       iy_q, iy_d;
  logic [7:0] disp_q, disp_d;
  logic       fire;

  assign in_ready = accept_en;
  assign fire     = in_valid && accept_en;

  always_comb begin
    st_d        = st_q;
    sfx_d       = sfx_q;
    idx_d       = idx_q;
    iy_d        = iy_q;
    disp_d      = disp_q;
    dec_valid   = 1'b0;
    dec.illegal = 1'b0;
    dec.is_mem  = 1'b0;
    dec.use_idx = idx_q;
    dec.sel_iy  = iy_q;
    dec.sfx     = sfx_q;
    dec.rrr     = in_byte[2:0];
    dec.disp    = disp_q;
    if (fire) begin
      unique case (st_q)
        D_FIRST: begin
          if (in_byte == OP_SFX_SHORT || in_byte == OP_SFX_LONG) begin
            if ((in_byte == OP_SFX_SHORT) == mode_wide) begin
              sfx_d = 1'b1;
              st_d  = D_SFX;
            end else begin
              dec_valid   = 1'b1;
              dec.illegal = 1'b1;
            end
          end else if (in_byte == OP_PFX_IX || in_byte == OP_PFX_IY) begin
            idx_d = 1'b1;
            iy_d  = (in_byte == OP_PFX_IY);
            st_d  = D_IDXCB;
          end else if (in_byte == OP_PFX_SHIFT) begin
            st_d = D_OP;
          end else begin
            dec_valid   = 1'b1;
            dec.illegal = 1'b1;
          end
        end
        D_SFX: begin
          if (in_byte == OP_PFX_IX || in_byte == OP_PFX_IY) begin
            idx_d = 1'b1;
            iy_d  = (in_byte == OP_PFX_IY);
            st_d  = D_IDXCB;
          end else if (in_byte == OP_PFX_SHIFT) begin
            st_d = D_OP;
          end else begin
            dec_valid   = 1'b1;
            dec.illegal = 1'b1;
          end
        end
        D_IDXCB: begin
          if (in_byte == OP_PFX_SHIFT) begin
            st_d = D_DISP;
          end else begin
            dec_valid   = 1'b1;
            dec.illegal = 1'b1;
          end
        end
        D_DISP: begin
          disp_d = in_byte;
          st_d   = D_OP;
        end
        D_OP: begin
          dec_valid  = 1'b1;
          dec.is_mem = (in_byte[2:0] == RRR_MEM);
          if (in_byte[7:3] != OP_SLA_HI) begin
            dec.illegal = 1'b1;
          end else if ((idx_q || sfx_q) && (in_byte[2:0] != RRR_MEM)) begin
            dec.illegal = 1'b1;
          end
        end
        default: st_d = D_FIRST;
      endcase
      if (dec_valid) begin
        st_d   = D_FIRST;
        sfx_d  = 1'b0;
        idx_d  = 1'b0;
        iy_d   = 1'b0;
        disp_d = 8'h00;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= D_FIRST;
      sfx_q  <= 1'b0;
      idx_q  <= 1'b0;
      iy_q   <= 1'b0;
      disp_q <= 8'h00;
    end else begin
      st_q   <= st_d;
      sfx_q  <= sfx_d;
      idx_q  <= idx_d;
      iy_q   <= iy_d;
      disp_q <= disp_d;
    end
  end

endmodule

// File: rtl/sla_exec_unit.sv
module sla_exec_unit
  import sla_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_wide,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [7:0]            in_byte,
  input  logic [55:0]           regs_in,
  input  logic [7:0]            flags_in,
  input  logic [ADDR_W-1:0]     ix_in,
  input  logic [ADDR_W-1:0]     iy_in,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic                  mem_rd_en,
  input  logic [7:0]            mem_rdata,
  output logic                  mem_wr_en,
  output logic [7:0]            mem_wdata,
  output logic                  res_valid,
  input  logic                  res_ready,
  output logic                  res_illegal,
  output logic                  res_mem,
  output logic [2:0]            res_reg,
  output logic [7:0]            res_data,
  output logic [7:0]            res_flags,
  output logic [CYC_W-1:0]      res_cycles
);

  localparam int NREG = 7;
  localparam int SLOT_A = NREG - 1;
  localparam int SLOT_H = 4;
  localparam int SLOT_L = 5;

  typedef enum logic [1:0] {E_IDLE, E_RD, E_WR, E_HOLD} estate_t;

  estate_t           est_q;
  dec_t              dec;
  logic              dec_valid;
  logic [7:0]        reg_bytes [NREG];
  logic [7:0]        reg_sel;
  logic [7:0]        alu_in, alu_res, alu_flags;
  logic [ADDR_W-1:0] hl_addr, eff_addr, addr_q;
  logic [CYC_W-1:0]  cyc_q;

  for (genvar g = 0; g < NREG; g++) begin : g_regs
    assign reg_bytes[g] = regs_in[8*g +: 8];
  end

  always_comb begin
    reg_sel = (dec.rrr == 3'b111) ? reg_bytes[SLOT_A] : reg_bytes[dec.rrr];
    hl_addr = '0;
    hl_addr[15:0] = {reg_bytes[SLOT_H], reg_bytes[SLOT_L]};
    if (dec.use_idx)
      eff_addr = (dec.sel_iy ? iy_in : ix_in)
               + {{(ADDR_W-8){dec.disp[7]}}, dec.disp};
    else
      eff_addr = hl_addr;
  end

  sla_prefix_decoder u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_wide (mode_wide),
    .accept_en (est_q == E_IDLE),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_byte   (in_byte),
    .dec_valid (dec_valid),
    .dec       (dec)
  );

  assign alu_in = (est_q == E_WR) ? mem_rdata : reg_sel;

  sla_shift_alu u_alu (
    .op_i    (alu_in),
    .flags_i (flags_in),
    .res_o   (alu_res),
    .flags_o (alu_flags)
  );

  assign mem_addr  = addr_q;
  assign mem_rd_en = (est_q == E_RD);
  assign mem_wr_en = (est_q == E_WR);
  assign mem_wdata = alu_res;
  assign res_valid = (est_q == E_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      est_q       <= E_IDLE;
      addr_q      <= '0;
      cyc_q       <= '0;
      res_illegal <= 1'b0;
      res_mem     <= 1'b0;
      res_reg     <= 3'b000;
      res_data    <= 8'h00;
      res_flags   <= 8'h00;
      res_cycles  <= '0;
    end else begin
      unique case (est_q)
        E_IDLE: begin
          if (dec_valid) begin
            if (dec.illegal) begin
              res_illegal <= 1'b1;
              res_mem     <= 1'b0;
              res_reg     <= 3'b000;
              res_data    <= 8'h00;
              res_flags   <= flags_in;
              res_cycles  <= '0;
              est_q       <= E_HOLD;
            end else if (!dec.is_mem) begin
              res_illegal <= 1'b0;
              res_mem     <= 1'b0;
              res_reg     <= dec.rrr;
              res_data    <= alu_res;
              res_flags   <= alu_flags;
              res_cycles  <= form_cycles(1'b0, 1'b0, dec.sfx);
              est_q       <= E_HOLD;
            end else begin
              addr_q <= eff_addr;
              cyc_q  <= form_cycles(1'b1, dec.use_idx, dec.sfx);
              est_q  <= E_RD;
            end
          end
        end
        E_RD: est_q <= E_WR;
        E_WR: begin
          res_illegal <= 1'b0;
          res_mem     <= 1'b1;
          res_reg     <= RRR_MEM;
          res_data    <= alu_res;
          res_flags   <= alu_flags;
          res_cycles  <= cyc_q;
          est_q       <= E_HOLD;
        end
        E_HOLD: if (res_ready) est_q <= E_IDLE;
        default: est_q <= E_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sla_exec_unit_chk.sv
module sla_exec_unit_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd_en,
  input logic              mem_wr_en,
  input logic              res_valid,
  input logic              res_ready,
  input logic              res_illegal,
  input logic [7:0]        res_data,
  input logic [7:0]        res_flags,
  input logic [3:0]        res_cycles
);

  AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> $past(mem_rd_en)); // R6

  AST_WR_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> mem_addr == $past(mem_addr)); // R6

  AST_RES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_flags))); // R11

  AST_NO_ACCEPT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !in_ready); // R11

  AST_HN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_illegal) |-> (!res_flags[4] && !res_flags[1])); // R3

  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_illegal) |-> (res_flags[6] == (res_data == 8'h00))); // R2

  AST_SIGN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_illegal) |-> (res_flags[7] == res_data[7])); // R2

  AST_CYCLES_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_illegal) |-> (res_cycles inside {4'd2, 4'd5, 4'd6, 4'd7, 4'd8})); // R9

  AST_ILLEGAL_ZERO_CYC: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_illegal) |-> (res_cycles == 4'd0)); // R10

endmodule

bind sla_exec_unit sla_exec_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .mem_addr    (mem_addr),
  .mem_rd_en   (mem_rd_en),
  .mem_wr_en   (mem_wr_en),
  .res_valid   (res_valid),
  .res_ready   (res_ready),
  .res_illegal (res_illegal),
  .res_data    (res_data),
  .res_flags   (res_flags),
  .res_cycles  (res_cycles)
);

// File: tb/sla_exec_unit_bench.sv
`timescale 1ns/1ps
module sla_exec_unit_bench;

  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              mode_wide = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [7:0]        in_byte = 8'h00;
  logic [55:0]       regs_in = '0;
  logic [7:0]        flags_in = 8'h00;
  logic [ADDR_W-1:0] ix_in = '0;
  logic [ADDR_W-1:0] iy_in = '0;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_rd_en;
  logic [7:0]        mem_rdata;
  logic              mem_wr_en;
  logic [7:0]        mem_wdata;
  logic              res_valid;
  logic              res_ready = 1'b0;
  logic              res_illegal;
  logic              res_mem;
  logic [2:0]        res_reg;
  logic [7:0]        res_data;
  logic [7:0]        res_flags;
  logic [3:0]        res_cycles;

  int n_checks = 0;
  int n_fails  = 0;

  logic [7:0]        mem [256];
  logic [ADDR_W-1:0] last_wr_addr = '0;
  logic [7:0]        last_wr_data = 8'h00;
  int                wr_count = 0;

  always #2 clk = ~clk;

  sla_exec_unit #(.ADDR_W(ADDR_W)) u_sla_exec_unit (
    .clk(clk), .rst_n(rst_n), .mode_wide(mode_wide),
    .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .regs_in(regs_in), .flags_in(flags_in), .ix_in(ix_in), .iy_in(iy_in),
    .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata),
    .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata),
    .res_valid(res_valid), .res_ready(res_ready), .res_illegal(res_illegal),
    .res_mem(res_mem), .res_reg(res_reg), .res_data(res_data),
    .res_flags(res_flags), .res_cycles(res_cycles)
  );

  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_wr_en) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      last_wr_addr <= mem_addr;
      last_wr_data <= mem_wdata;
      wr_count     <= wr_count + 1;
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    summary();
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic set_reg(input logic [2:0] code, input logic [7:0] val);
    int slot = (code == 3'b111) ? 6 : int'(code);
    regs_in[8*slot +: 8] = val;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic wait_res();
    @(negedge clk);
    while (!res_valid) @(negedge clk);
  endtask

  task automatic take_res();
    res_ready = 1'b1;
    @(posedge clk);
    #1 res_ready = 1'b0;
  endtask

  function automatic logic [7:0] exp_flags(input logic [7:0] op, input logic [7:0] fin);
    logic [7:0] r, f;
    r = {op[6:0], 1'b0};
    f = fin;
    f[7] = r[7];
    f[6] = (r == 8'h00);
    f[4] = 1'b0;
    f[2] = ~^r;
    f[1] = 1'b0;
    f[0] = op[7];
    return f;
  endfunction

  task automatic check_legal(input string tag, input logic [7:0] op,
                             input logic is_mem, input logic [2:0] rrr,
                             input int cyc);
    logic [7:0] ef = exp_flags(op, flags_in);
    wait_res();
    chk(res_illegal == 1'b0, {tag, " R10 legal"}, res_illegal, 0);
    chk(res_data == {op[6:0], 1'b0}, {tag, " R1 data"}, res_data, {op[6:0], 1'b0});
    chk(res_flags == ef, {tag, " R1 R2 R3 R4 flags"}, res_flags, ef);
    chk(res_mem == is_mem, {tag, " R5 mem"}, res_mem, is_mem);
    chk(res_reg == rrr, {tag, " R5 reg"}, res_reg, rrr);
    chk(res_cycles == cyc, {tag, " R9 cycles"}, res_cycles, cyc);
    take_res();
  endtask

  task automatic check_illegal(input string tag, input int wr_before);
    wait_res();
    chk(res_illegal == 1'b1, {tag, " R10 illegal"}, res_illegal, 1);
    chk(res_flags == flags_in, {tag, " R10 flags kept"}, res_flags, flags_in);
    chk(res_cycles == 4'd0, {tag, " R10 cycles"}, res_cycles, 0);
    chk(wr_count == wr_before, {tag, " R10 no write"}, wr_count, wr_before);
    take_res();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(in_ready == 1'b1, "reset R11 in_ready", in_ready, 1);
    chk(res_valid == 1'b0, "reset R11 res_valid", res_valid, 0);
    chk(mem_wr_en == 1'b0 && mem_rd_en == 1'b0, "reset R6 mem idle",
        {mem_rd_en, mem_wr_en}, 0);
  endtask

  task automatic t_register_forms();
    logic [7:0] vals [7] = '{8'h81, 8'h40, 8'h3C, 8'hFF, 8'h12, 8'hA5, 8'h7E};
    logic [2:0] codes [7] = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b100, 3'b101, 3'b111};
    flags_in = 8'h00;
    for (int k = 0; k < 7; k++) set_reg(codes[k], vals[k]);
    for (int k = 0; k < 7; k++) begin
      push(8'hCB);
      push({5'b00100, codes[k]});
      check_legal($sformatf("regform%0d R5", k), vals[k], 1'b0, codes[k], 2);
    end
  endtask

  task automatic t_flag_patterns();
    logic [7:0] ops [4] = '{8'h80, 8'h41, 8'h01, 8'h00};
    flags_in = 8'hFF;
    for (int k = 0; k < 4; k++) begin
      set_reg(3'b111, ops[k]);
      push(8'hCB);
      push(8'h27);
      check_legal($sformatf("flags%0d R4", k), ops[k], 1'b0, 3'b111, 2);
    end
    flags_in = 8'h00;
  endtask

  task automatic t_hl_form();
    int wb;
    set_reg(3'b100, 8'h12);
    set_reg(3'b101, 8'h34);
    mem[8'h34] = 8'hC3;
    wb = wr_count;
    push(8'hCB);
    push(8'h26);
    check_legal("hl R6", 8'hC3, 1'b1, 3'b110, 5);
    chk(last_wr_addr == 16'h1234, "hl R6 addr", last_wr_addr, 16'h1234);
    chk(mem[8'h34] == 8'h86, "hl R6 writeback", mem[8'h34], 8'h86);
    chk(wr_count == wb + 1, "hl R6 one write", wr_count, wb + 1);
  endtask

  task automatic t_indexed();
    ix_in = 16'h2010;
    mem[8'h00] = 8'h55;
    push(8'hDD); push(8'hCB); push(8'hF0); push(8'h26);
    check_legal("ix R7", 8'h55, 1'b1, 3'b110, 7);
    chk(last_wr_addr == 16'h2000, "ix R7 negative disp addr", last_wr_addr, 16'h2000);
    chk(last_wr_data == 8'hAA, "ix R7 data", last_wr_data, 8'hAA);
    iy_in = 16'h3000;
    mem[8'h05] = 8'h81;
    push(8'hFD); push(8'hCB); push(8'h05); push(8'h26);
    check_legal("iy R7", 8'h81, 1'b1, 3'b110, 7);
    chk(last_wr_addr == 16'h3005, "iy R7 positive disp addr", last_wr_addr, 16'h3005);
  endtask

  task automatic t_suffix();
    set_reg(3'b100, 8'h12);
    set_reg(3'b101, 8'h40);
    mem[8'h40] = 8'h09;
    mode_wide = 1'b1;
    push(8'h52); push(8'hCB); push(8'h26);
    check_legal("short sfx R8", 8'h09, 1'b1, 3'b110, 6);
    mode_wide = 1'b0;
    mem[8'h40] = 8'h60;
    push(8'h49); push(8'hCB); push(8'h26);
    check_legal("long sfx R8", 8'h60, 1'b1, 3'b110, 6);
    iy_in = 16'h3000;
    mem[8'h05] = 8'h33;
    push(8'h49); push(8'hFD); push(8'hCB); push(8'h05); push(8'h26);
    check_legal("long sfx iy R9", 8'h33, 1'b1, 3'b110, 8);
    chk(last_wr_addr == 16'h3005, "long sfx iy R7 addr", last_wr_addr, 16'h3005);
    set_reg(3'b000, 8'h11);
    push(8'hCB); push(8'h20);
    check_legal("after sfx R9 no carry-over", 8'h11, 1'b0, 3'b000, 2);
  endtask

  task automatic t_illegal();
    flags_in = 8'h6B;
    mode_wide = 1'b0;
    push(8'h52);
    check_illegal("short in narrow mode R8", wr_count);
    mode_wide = 1'b1;
    push(8'h49);
    check_illegal("long in wide mode R8", wr_count);
    push(8'h52); push(8'hCB); push(8'h20);
    check_illegal("sfx with register R8", wr_count);
    push(8'hDD); push(8'hCB); push(8'h00); push(8'h27);
    check_illegal("indexed register R10", wr_count);
    push(8'hCB); push(8'h30);
    check_illegal("other op R10", wr_count);
    push(8'h00);
    check_illegal("bad first R10", wr_count);
    push(8'hFD); push(8'h00);
    check_illegal("bad after index R10", wr_count);
    mode_wide = 1'b0;
    flags_in = 8'h00;
    set_reg(3'b010, 8'h02);
    push(8'hCB); push(8'h22);
    check_legal("recovery R10", 8'h02, 1'b0, 3'b010, 2);
  endtask

  task automatic t_backpressure();
    logic [7:0] d0, f0;
    set_reg(3'b011, 8'hC0);
    push(8'hCB); push(8'h23);
    wait_res();
    d0 = res_data;
    f0 = res_flags;
    repeat (5) @(negedge clk);
    chk(res_valid == 1'b1, "bp R11 held valid", res_valid, 1);
    chk(res_data == d0 && res_flags == f0, "bp R11 stable", {res_data, res_flags}, {d0, f0});
    chk(in_ready == 1'b0, "bp R11 no accept", in_ready, 0);
    chk(res_data == 8'h80, "bp R1 data", res_data, 8'h80);
    take_res();
    @(negedge clk);
    chk(res_valid == 1'b0 && in_ready == 1'b1, "bp R11 released",
        {res_valid, in_ready}, 1);
  endtask

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = 8'h00;
    mem_rdata = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_register_forms();
    t_flag_patterns();
    t_hl_form();
    t_indexed();
    t_suffix();
    t_illegal();
    t_backpressure();
    summary();
  end

endmodule